// File: doc/BRIEF.md
# Single-Line Trigger-Selectable Interrupt Front End

This block watches one external interrupt line and turns qualifying activity on it into a single interrupt request for a processor. The line is first brought into the local clock domain. It is then compared against one of four trigger conditions: active-low level, active-high level, rising edge or falling edge. A detected event sets a sticky pending flag. The flag is masked by an enable flag, and the result drives a registered interrupt output.

Software controls the block through three registers on a small byte-addressed bus with separate read and write strobes. The mode register holds the trigger selection in its two lowest bits, and its remaining bits are plain read/write storage. The status register shows the pending flag and clears it on a write of one. The mask register holds the enable flag. One parameter chooses where these three registers sit in the address space, so the block fits any of three fixed maps.

To bring the block up, software first clears the enable flag and then writes one to the pending flag. This discards anything captured before the block was configured.

Top module: `nmi_ctrl`

## Requirements
- R1: After reset the mode register, the status register and the mask register all read 0, and `irq_out` is low. A mode value of 0 selects active-low level.
- R2: In level modes, the mode bits [1:0] work as follows. Value 0 sets the pending flag while the synchronized line is low, and value 2 sets it while the line is high.
- R3: In edge modes, value 3 sets the pending flag once on a low-to-high transition and value 1 sets it once on a high-to-low transition. After an acknowledge, a line that stays steady does not set the flag again.
- R4: In a level mode, an acknowledge issued while the active level persists leaves the flag reading 1 afterwards.
- R5: The status register reports the pending flag in bit 0. Writing 1 to bit 0 clears the flag, and writing 0 leaves it unchanged.
- R6: The mask register holds the enable flag in bit 0. `irq_out` is the registered AND of the pending and enable flags, so with enable at 0 the output stays low while the flag remains set.
- R7: The mode register stores all DATA_W bits as read/write storage. A write followed by a read returns the written value.
- R8: The LAYOUT parameter selects the register offsets. Layout 0 places mode, status and mask at 0x00, 0x04 and 0x08. Layout 1 places them at 0x00, 0x04 and 0x34. Layout 2 places mode at 0x00, mask at 0x04 and status at 0x08.
- R9: A read of any unmapped offset returns 0, and a write to one changes no register.
- R10: When an event and a write of 1 to the status register fall in the same cycle, the event wins and the flag stays set.
- R11: After the bring-up sequence (write 0 to the mask register, then write 1 to the status register), `irq_out` stays low and the flag reads 0 while the line shows no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | External interrupt line, asynchronous to clk_i |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; data appears on bus_rdata_o one cycle later |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The trigger logic is driven with steady low and steady high levels, and with single rising and falling transitions, in each of the four modes. Each pattern is followed by an acknowledge. Level and edge behaviour differ only in whether the flag comes back after that acknowledge, so this sequence tells them apart. A falling transition is timed to reach the detector in the same cycle as an acknowledge, which shows whether the event or the clear takes priority. A second instance built with layout 2 shows that the status and mask offsets swap, and accesses to unmapped offsets show that they read as zero and change nothing.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'd0,
        TRIG_FALL   = 2'd1,
        TRIG_LVL_HI = 2'd2,
        TRIG_RISE   = 2'd3
    } trig_mode_e;

    localparam int MAP_A = 0;
    localparam int MAP_B = 1;
    localparam int MAP_C = 2;

    function automatic logic [7:0] mode_offset(input int layout);
        return (layout >= 0) ? 8'h00 : 8'h00;
    endfunction

    function automatic logic [7:0] status_offset(input int layout);
        return (layout == MAP_C) ? 8'h08 : 8'h04;
    endfunction

    function automatic logic [7:0] mask_offset(input int layout);
        case (layout)
            MAP_A:   return 8'h08;
            MAP_B:   return 8'h34;
            default: return 8'h04;
        endcase
    endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{IDLE}};
        else         chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
    import nmi_pkg::*;
#(
    parameter logic IDLE = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       level_i,
    input  trig_mode_e mode_i,
    output logic       event_o
);
    typedef struct packed {
        logic prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = level_i;
        event_o    = 1'b0;
        unique case (mode_i)
            TRIG_LVL_LO: event_o = !level_i;
            TRIG_FALL:   event_o = det_q.prev && !level_i;
            TRIG_LVL_HI: event_o = level_i;
            TRIG_RISE:   event_o = !det_q.prev && level_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) det_q <= '{prev: IDLE};
        else         det_q <= det_d;
    end

    // R3: a steady line never raises an edge event
    p_steady_no_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i inside {TRIG_FALL, TRIG_RISE}) && (level_i == det_q.prev) |-> !event_o);
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
    import nmi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LAYOUT = MAP_A
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              event_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output trig_mode_e        mode_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] OFF_MODE   = ADDR_W'(mode_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(status_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] OFF_MASK   = ADDR_W'(mask_offset(LAYOUT));

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic              pending;
        logic              enable;
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_mode, hit_status, hit_mask, ack;

    always_comb begin
        hit_mode   = (addr_i == OFF_MODE);
        hit_status = (addr_i == OFF_STATUS);
        hit_mask   = (addr_i == OFF_MASK);
        ack        = wr_i && hit_status && wdata_i[0];

        r_d = r_q;
        if (wr_i && hit_mode) r_d.mode   = wdata_i;
        if (wr_i && hit_mask) r_d.enable = wdata_i[0];

        if (event_i)  r_d.pending = 1'b1;
        else if (ack) r_d.pending = 1'b0;

        r_d.irq = r_q.pending && r_q.enable;

        if (rd_i) begin
            if (hit_mode)        r_d.rdata = r_q.mode;
            else if (hit_status) r_d.rdata = DATA_W'(r_q.pending);
            else if (hit_mask)   r_d.rdata = DATA_W'(r_q.enable);
            else                 r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rdata_o = r_q.rdata;
    assign mode_o  = trig_mode_e'(r_q.mode[1:0]);
    assign irq_o   = r_q.irq;

    // R6: a masked flag never reaches the output
    p_mask_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !r_q.enable |=> !irq_o);
    // R10: an event always leaves the flag set
    p_event_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i |=> r_q.pending);
    // R5: an acknowledge without an event clears the flag
    p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && hit_status && wdata_i[0] && !event_i) |=> !r_q.pending);
    // R5: with no event and no status write the flag holds
    p_pending_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!event_i && !(wr_i && hit_status)) |=> $stable(r_q.pending));
    // R9: writes outside the map change nothing
    p_unmapped_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !hit_mode && !hit_status && !hit_mask) |=> ($stable(r_q.mode) && $stable(r_q.enable)));
endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl
    import nmi_pkg::*;
#(
    parameter int   ADDR_W      = 8,
    parameter int   DATA_W      = 32,
    parameter int   LAYOUT      = MAP_A,
    parameter int   SYNC_STAGES = 2,
    parameter logic LINE_IDLE   = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              line_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_out
);
    logic       line_sync;
    logic       trig_event;
    trig_mode_e trig_mode;

    nmi_sync #(.STAGES(SYNC_STAGES), .IDLE(LINE_IDLE)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (line_i),
        .level_o(line_sync)
    );

    nmi_detect #(.IDLE(LINE_IDLE)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(line_sync),
        .mode_i (trig_mode),
        .event_o(trig_event)
    );

    nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .event_i(trig_event),
        .addr_i (bus_addr_i),
        .wr_i   (bus_wr_i),
        .rd_i   (bus_rd_i),
        .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o),
        .mode_o (trig_mode),
        .irq_o  (irq_out)
    );

    // R2: a held high level in high-level mode raises an event
    p_level_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_mode == TRIG_LVL_HI) && line_sync |-> trig_event);
endmodule

// File: tb/nmi_ctrl_tb_top.sv
`timescale 1ns/1ps
module nmi_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_a = 1'b0, rd_a = 1'b0, wr_c = 1'b0, rd_c = 1'b0;
    logic [31:0] rdata_a, rdata_c;
    logic        irq_a, irq_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_val_q[$];
    string       exp_tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    nmi_ctrl #(.LAYOUT(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .bus_addr_i(addr),
        .bus_wr_i(wr_a), .bus_rd_i(rd_a), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_a), .irq_out(irq_a));

    nmi_ctrl #(.LAYOUT(2)) dut_c_i (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .bus_addr_i(addr),
        .bus_wr_i(wr_c), .bus_rd_i(rd_c), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_c), .irq_out(irq_c));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= rd_a;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_val_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard actual %h expected none", rdata_a);
            end else begin
                chk(exp_tag_q.pop_front(), rdata_a, exp_val_q.pop_front());
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit to_c, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (to_c) wr_c = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_c = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_a = 1'b1;
        exp_val_q.push_back(exp);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        rd_a = 1'b0;
    endtask

    task automatic rdc(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_c = 1'b1;
        @(negedge clk);
        rd_c = 1'b0;
        chk(tag, rdata_c, exp);
    endtask

    localparam logic [7:0] A_MODE = 8'h00, A_STAT = 8'h04, A_MASK = 8'h08;
    localparam logic [31:0] UPPER = 32'hABCD_1230;

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 irq", {31'd0, irq_a}, 32'd0);
        rd(A_MODE, 32'd0, "R1 mode");
        rd(A_STAT, 32'd0, "R1 status");
        rd(A_MASK, 32'd0, "R1 mask");

        // R7 full-width storage, low bits 0 keep low-level mode
        wr(0, A_MODE, UPPER);
        rd(A_MODE, UPPER, "R7 readback");

        // R2 low level
        wr(0, A_MASK, 32'd1);
        line = 1'b0;
        cyc(5);
        chk("R2 irq low-level", {31'd0, irq_a}, 32'd1);
        rd(A_STAT, 32'd1, "R2 pending low-level");
        // R4 ack under active level
        wr(0, A_STAT, 32'd1);
        rd(A_STAT, 32'd1, "R4 pending re-set");
        line = 1'b1;
        cyc(4);
        wr(0, A_STAT, 32'd1);
        cyc(3);
        rd(A_STAT, 32'd0, "R4 cleared after release");
        chk("R6 irq follows clear", {31'd0, irq_a}, 32'd0);

        // R2 high level
        wr(0, A_MODE, UPPER | 32'd2);
        cyc(4);
        rd(A_STAT, 32'd1, "R2 pending high-level");
        line = 1'b0;
        cyc(4);
        wr(0, A_STAT, 32'd1);
        rd(A_STAT, 32'd0, "R2 cleared high-level");

        // R3 rising edge
        wr(0, A_MODE, UPPER | 32'd3);
        cyc(3);
        rd(A_STAT, 32'd0, "R3 no event while low");
        line = 1'b1;
        cyc(5);
        rd(A_STAT, 32'd1, "R3 rising sets");
        chk("R3 irq rising", {31'd0, irq_a}, 32'd1);
        wr(0, A_STAT, 32'd1);
        cyc(4);
        rd(A_STAT, 32'd0, "R3 steady high no re-set");

        // R3 falling edge, R5 write-zero
        wr(0, A_MODE, UPPER | 32'd1);
        line = 1'b0;
        cyc(5);
        rd(A_STAT, 32'd1, "R3 falling sets");
        wr(0, A_STAT, 32'd0);
        rd(A_STAT, 32'd1, "R5 write zero no effect");
        wr(0, A_STAT, 32'd1);
        cyc(3);
        rd(A_STAT, 32'd0, "R5 write one clears");

        // R10 event and ack in the same cycle
        line = 1'b1;
        cyc(5);
        rd(A_STAT, 32'd0, "R10 precondition clear");
        @(negedge clk); line = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = A_STAT; wdata = 32'd1; wr_a = 1'b1;
        @(negedge clk); wr_a = 1'b0;
        rd(A_STAT, 32'd1, "R10 event wins");

        // R6 mask
        cyc(2);
        chk("R6 irq enabled", {31'd0, irq_a}, 32'd1);
        wr(0, A_MASK, 32'd0);
        cyc(2);
        chk("R6 irq masked", {31'd0, irq_a}, 32'd0);
        rd(A_STAT, 32'd1, "R6 pending kept when masked");
        rd(A_MASK, 32'd0, "R6 mask reads 0");

        // R11 bring-up
        wr(0, A_MASK, 32'd1);
        cyc(2);
        chk("R11 irq before bring-up", {31'd0, irq_a}, 32'd1);
        wr(0, A_MASK, 32'd0);
        wr(0, A_STAT, 32'd1);
        cyc(5);
        chk("R11 irq after bring-up", {31'd0, irq_a}, 32'd0);
        rd(A_STAT, 32'd0, "R11 pending after bring-up");

        // R9 unmapped
        wr(0, 8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'd0, "R9 unmapped read 0C");
        rd(8'h10, 32'd0, "R9 unmapped read 10");
        rd(A_MODE, UPPER | 32'd1, "R9 mode untouched");
        rd(A_MASK, 32'd0, "R9 mask untouched");
        rd(A_STAT, 32'd0, "R9 status untouched");

        // R8 layout 2: mask at 0x04, status at 0x08
        line = 1'b1;
        cyc(4);
        wr(1, 8'h08, 32'd1);
        wr(1, 8'h04, 32'd1);
        rdc(8'h04, 32'd1, "R8 layout2 mask at 04");
        rdc(8'h08, 32'd0, "R8 layout2 status at 08");
        line = 1'b0;
        cyc(5);
        rdc(8'h08, 32'd1, "R8 layout2 pending at 08");
        chk("R8 layout2 irq", {31'd0, irq_c}, 32'd1);
        line = 1'b1;
        cyc(4);

        cyc(3);
        if (exp_val_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard actual %0d left expected 0", exp_val_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule